// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block models a small synchronous static memory with a pipelined read path. Reads and writes can be issued on consecutive clock cycles in any mix, with no idle cycle between them. Commands are sampled on the rising clock edge. Read data comes from an output register one enabled edge after the command. Write data is taken from the bus two enabled edges after the write command. Both kinds of transfer therefore use the same bus slot, so the bus never needs a turnaround gap.

A clock enable freezes the whole pipeline. Three chip selects gate each new command. An advance input steps an internal four-beat burst counter instead of loading a fresh address. The counter order is either linear or interleaved. An asynchronous output enable and an asynchronous sleep input control the data drivers without waiting for a clock. Sleep also blocks new commands. The shared data bus appears as separate input and output ports plus a drive-enable flag.

Top module: `pipe_sram`

## Requirements
- R1: A write with all byte enables high stores the `dq_in` value present at the second enabled clock edge after the edge that accepted the command. A later read returns that value.
- R2: A read accepted at enabled edge n drives the addressed word on `dq_out`, with `dq_oe` high, after enabled edge n+1. Reads and writes may alternate on every cycle with no idle cycle.
- R3: `byte_en[i]` selects bits [i*LANE_W +: LANE_W] of a write, and bytes whose enable is low keep their stored value. Byte enables have no effect on reads.
- R4: A read accepted on the cycle after a write to the same address returns the newly written bytes, merged over the stored bytes according to that write's byte enables.
- R5: While `clk_en` is low, no command is accepted, no write lands, and `dq_out`/`dq_oe` hold their values.
- R6: A load cycle (`adv`=0) takes effect only when `sel_a`=1, `sel_b`=1 and `sel_n`=0. Any other combination is a bubble: nothing is written, and `dq_oe` is low in the matching output slot.
- R7: `oe_async`=0 forces `dq_oe` low at once, with no clock edge needed. Returning it to 1 restores the held read data.
- R8: `sleep`=1 forces `dq_oe` low at once. Commands presented while asleep are ignored, and stored data is kept.
- R9: `adv`=1 continues the last loaded command's direction. It steps the two low address bits over four beats, with the upper bits fixed: base+k mod 4 when `burst_lin`=1, and base XOR k when `burst_lin`=0.
- R10: `adv`=1 with no burst in progress (after reset, or after a deselected load) is a bubble.
- R11: Synchronous reset empties the pipeline, so `dq_oe` is low and no burst is active. Memory contents are not cleared.
- R12: In the output slot of any cycle that is not a read, the read-valid flag is low, so `dq_oe` stays low during write-data slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; low stalls everything |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr | input | 1 | 1 = write, 0 = read (load cycles) |
| byte_en | input | LANES | Per-byte write enables, active high |
| addr | input | ADDR_W | Word address |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_async | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down request |
| dq_in | input | LANES*LANE_W | Bus value seen by the memory |
| dq_out | output | LANES*LANE_W | Read data driven onto the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the default configuration: 4 address bits, 2 byte lanes and 9-bit lanes. With only 16 words, every location can be written and read back in back-to-back sweeps. Two lanes let each byte enable be exercised alone, both from the array and through the forwarding path. Because the burst base sits inside such a small space, both counting orders and their wrap back to the start of the aligned group of four become directly observable.

// File: rtl/pipe_sram_pkg.sv
`timescale 1ns/1ps
package pipe_sram_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} op_e;

  // Low-address-bit sequence for beat k of a four-beat burst
  function automatic logic [1:0] burst_ofs(input logic [1:0] base,
                                           input logic [1:0] k,
                                           input logic lin);
    return lin ? (base + k) : (base ^ k);
  endfunction
endpackage

// File: rtl/pipe_sram_ctrl.sv
`timescale 1ns/1ps
module pipe_sram_ctrl #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        sel_ok,
  input  logic                        adv,
  input  logic                        wr,
  input  logic [LANES-1:0]            byte_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        lin,
  input  logic                        sleep,
  output pipe_sram_pkg::op_e          s1_op,
  output logic [ADDR_W-1:0]           s1_addr,
  output logic [LANES-1:0]            s1_be
);
  import pipe_sram_pkg::*;

  logic              b_live, b_wr;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt, nxt_cnt;
  logic [ADDR_W-1:0] burst_addr;

  assign nxt_cnt    = b_cnt + 2'd1;
  assign burst_addr = {b_base[ADDR_W-1:2], burst_ofs(b_base[1:0], nxt_cnt, lin)};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op  <= OP_IDLE;
      b_live <= 1'b0;
      b_cnt  <= 2'd0;
    end else if (en) begin
      if (sleep) begin
        s1_op <= OP_IDLE;
      end else if (!adv) begin
        if (sel_ok) begin
          s1_op   <= wr ? OP_WRITE : OP_READ;
          s1_addr <= addr;
          s1_be   <= byte_en;
          b_live  <= 1'b1;
          b_wr    <= wr;
          b_base  <= addr;
          b_cnt   <= 2'd0;
        end else begin
          s1_op  <= OP_IDLE;
          b_live <= 1'b0;
        end
      end else if (b_live) begin
        s1_op   <= b_wr ? OP_WRITE : OP_READ;
        s1_addr <= burst_addr;
        s1_be   <= byte_en;
        b_cnt   <= nxt_cnt;
      end else begin
        s1_op <= OP_IDLE;
      end
    end
  end
endmodule

// File: rtl/pipe_sram_array.sv
`timescale 1ns/1ps
module pipe_sram_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      en,
  input  logic                      we,
  input  logic [LANES-1:0]          wbe,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_lane;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && wbe[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        rd_lane <= mem[raddr];
      end
    end
    assign rdata[g*LANE_W +: LANE_W] = rd_lane;
  end
endmodule

// File: rtl/pipe_sram_out.sv
`timescale 1ns/1ps
module pipe_sram_out #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      rd_now,
  input  logic [LANES-1:0]          hit_be,
  input  logic [LANES*LANE_W-1:0]   din,
  input  logic [LANES*LANE_W-1:0]   rdata,
  input  logic                      oe_async,
  input  logic                      sleep,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_oe,
  output logic                      rd_vld
);
  logic [LANES-1:0]        fmask;
  logic [LANES*LANE_W-1:0] fdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      fmask  <= '0;
    end else if (en) begin
      rd_vld <= rd_now;
      fmask  <= hit_be;
      fdata  <= din;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign dq_out[g*LANE_W +: LANE_W] = fmask[g] ? fdata[g*LANE_W +: LANE_W]
                                                 : rdata[g*LANE_W +: LANE_W];
  end

  assign dq_oe = rd_vld & oe_async & ~sleep;
endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clk_en,
  input  logic                        sel_a,
  input  logic                        sel_b,
  input  logic                        sel_n,
  input  logic                        adv,
  input  logic                        wr,
  input  logic [LANES-1:0]            byte_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        burst_lin,
  input  logic                        oe_async,
  input  logic                        sleep,
  input  logic [LANES*LANE_W-1:0]     dq_in,
  output logic [LANES*LANE_W-1:0]     dq_out,
  output logic                        dq_oe
);
  import pipe_sram_pkg::*;
  localparam int DATA_W = LANES * LANE_W;

  logic              sel_ok;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be, hit_be;
  logic              s2_wr, rd_vld;
  logic [DATA_W-1:0] rdata;

  assign sel_ok = sel_a & sel_b & ~sel_n;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rst(rst), .en(clk_en), .sel_ok(sel_ok), .adv(adv), .wr(wr),
    .byte_en(byte_en), .addr(addr), .lin(burst_lin), .sleep(sleep),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
  );

  // Write-address stage: data joins the write one enabled edge later
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_wr <= 1'b0;
    end else if (clk_en) begin
      s2_wr   <= (s1_op == OP_WRITE);
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  assign hit_be = (s2_wr && s1_op == OP_READ && s2_addr == s1_addr) ? s2_be : '0;

  pipe_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .en(clk_en), .we(s2_wr), .wbe(s2_be), .waddr(s2_addr),
    .wdata(dq_in), .raddr(s1_addr), .rdata(rdata)
  );

  pipe_sram_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst(rst), .en(clk_en), .rd_now(s1_op == OP_READ),
    .hit_be(hit_be), .din(dq_in), .rdata(rdata), .oe_async(oe_async),
    .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe), .rd_vld(rd_vld)
  );
endmodule

// File: rtl/pipe_sram_chk.sv
`timescale 1ns/1ps
module pipe_sram_chk #(
  parameter int DW = 18
) (
  input logic               clk,
  input logic               rst,
  input logic               clk_en,
  input logic               adv,
  input logic               sel_ok,
  input logic               sleep,
  input logic               oe_async,
  input pipe_sram_pkg::op_e s1_op,
  input logic               rd_vld,
  input logic [DW-1:0]      dq_out,
  input logic               dq_oe
);
  import pipe_sram_pkg::*;

  a_r2_read_slot: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s1_op == OP_READ) |=> rd_vld);

  a_r12_write_slot_quiet: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s1_op != OP_READ) |=> !rd_vld);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(dq_out) && $stable(rd_vld));

  a_r6_deselect_bubble: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv && !sel_ok) |=> s1_op == OP_IDLE);

  a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
    (clk_en && sleep) |=> s1_op == OP_IDLE);

  a_r8_sleep_tristate: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dq_oe);

  a_r7_oe_gate: assert property (@(posedge clk) disable iff (rst)
    !oe_async |-> !dq_oe);
endmodule

bind pipe_sram pipe_sram_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .adv(adv), .sel_ok(sel_ok),
  .sleep(sleep), .oe_async(oe_async), .s1_op(s1_op), .rd_vld(rd_vld),
  .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/pipe_sram_bench.sv
`timescale 1ns/1ps
module pipe_sram_bench;
  logic        clk = 1'b0, rst = 1'b1, clk_en = 1'b1;
  logic        sel_a = 1'b0, sel_b = 1'b1, sel_n = 1'b0;
  logic        adv = 1'b0, wr = 1'b0, burst_lin = 1'b1;
  logic        oe_async = 1'b1, sleep = 1'b0;
  logic [1:0]  byte_en = 2'b11;
  logic [3:0]  addr = '0;
  logic [17:0] dq_in = '0;
  logic [17:0] dq_out;
  logic        dq_oe;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pipe_sram u_pipe_sram (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sel_a(sel_a), .sel_b(sel_b),
    .sel_n(sel_n), .adv(adv), .wr(wr), .byte_en(byte_en), .addr(addr),
    .burst_lin(burst_lin), .oe_async(oe_async), .sleep(sleep),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 18'h0B3D) + 18'h1234);
  endfunction

  function automatic logic [17:0] alt(input int a);
    return pat(a) ^ 18'h2AAAA;
  endfunction

  task automatic chk(input string rq, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // One clock: apply inputs, pass the edge, return at the following negedge
  task automatic cyc(input logic en, input logic sel, input logic a, input logic w,
                     input logic [1:0] be, input logic [3:0] ad, input logic [17:0] wd);
    clk_en = en; sel_a = sel; adv = a; wr = w; byte_en = be; addr = ad; dq_in = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop(input logic [17:0] wd);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 4'd0, wd);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R11 oe after reset", 18'(dq_oe), 18'd0);

    // R10: advance with no burst after reset is a bubble
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0);
    nop('0);
    chk("R10 adv after reset", 18'(dq_oe), 18'd0);

    // R1: fill all words back to back, data two cycles after each command
    for (int i = 0; i < 18; i++) begin
      if (i < 16) cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 4'(i), (i >= 2) ? pat(i-2) : '0);
      else nop(pat(i-2));
    end
    // R2: back-to-back reads
    for (int i = 0; i < 17; i++) begin
      if (i < 16) cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 4'(i), '0);
      else nop('0);
      if (i >= 1) begin
        chk("R2 read oe", 18'(dq_oe), 18'd1);
        chk("R1 readback", dq_out, pat(i-1));
      end
    end
    nop('0);
    chk("R12 idle slot oe", 18'(dq_oe), 18'd0);

    // R4: read right after write, full forward
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 4'd3, '0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 4'd3, '0);
    chk("R12 write data slot oe", 18'(dq_oe), 18'd0);
    nop(~pat(3));
    chk("R4 forward full", dq_out, ~pat(3));

    // R4 + R3: partial forward, only upper lane
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 4'd6, '0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 4'd6, '0);
    nop('0);
    chk("R4 forward upper lane", dq_out, {9'h0, pat(6)[8:0]});

    // R3: lower lane only through the array
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 4'd5, '0);
    nop('0);
    nop(18'h3FFFF);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 4'd5, '0);
    nop('0);
    chk("R3 lower lane write", dq_out, {pat(5)[17:9], 9'h1FF});

    // R5: stall with a write presented, then release
    nop('0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'd7, '0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 4'd0, 18'h15555);
      chk("R5 stall keeps slot", 18'(dq_oe), 18'd0);
    end
    nop('0);
    chk("R5 read after stall", dq_out, pat(7));
    for (int i = 0; i < 2; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 4'd9, 18'h15555);
      chk("R5 output held", dq_out, pat(7));
      chk("R5 oe held", 18'(dq_oe), 18'd1);
    end
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'd0, '0);
    nop('0);
    chk("R5 stalled write ignored", dq_out, pat(0));

    // R6: each select alone blocks a read
    for (int s = 0; s < 3; s++) begin
      sel_b = (s != 1); sel_n = (s == 2);
      cyc(1'b1, (s != 0), 1'b0, 1'b0, 2'b11, 4'd8, '0);
      sel_b = 1'b1; sel_n = 1'b0;
      nop('0);
      chk("R6 deselected read oe", 18'(dq_oe), 18'd0);
    end
    sel_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 4'd9, '0);
    sel_n = 1'b0;
    nop('0); nop(18'h00ABC);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'd9, '0);
    nop('0);
    chk("R6 deselected write ignored", dq_out, pat(9));

    // R7: asynchronous output enable
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'd10, '0);
    nop('0);
    oe_async = 1'b0; #1;
    chk("R7 oe forced low", 18'(dq_oe), 18'd0);
    oe_async = 1'b1; #1;
    chk("R7 oe restored", 18'(dq_oe), 18'd1);
    chk("R7 data held", dq_out, pat(10));

    // R8: sleep
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'd11, '0);
    nop('0);
    sleep = 1'b1; #1;
    chk("R8 sleep tristate", 18'(dq_oe), 18'd0);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 4'd11, '0);
    nop('0);
    nop(18'h0);
    sleep = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'd11, '0);
    nop('0);
    chk("R8 contents kept", dq_out, pat(11));

    // R9: linear read burst from 13 -> 13,14,15,12
    burst_lin = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'd13, '0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0); chk("R9 linear beat0", dq_out, pat(13));
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0); chk("R9 linear beat1", dq_out, pat(14));
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0); chk("R9 linear beat2", dq_out, pat(15));
    nop('0);                                        chk("R9 linear beat3", dq_out, pat(12));
    // R9: interleaved read burst from 13 -> 13,12,15,14
    burst_lin = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'd13, '0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0); chk("R9 interleaved beat0", dq_out, pat(13));
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0); chk("R9 interleaved beat1", dq_out, pat(12));
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0); chk("R9 interleaved beat2", dq_out, pat(15));
    nop('0);                                        chk("R9 interleaved beat3", dq_out, pat(14));

    // R10: advance after a deselected load is a bubble
    nop('0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0);
    nop('0);
    chk("R10 adv after deselect", 18'(dq_oe), 18'd0);

    // R9: linear write burst from 2 -> 2,3,0,1
    burst_lin = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 4'd2, '0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, '0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, alt(2));
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, 4'd0, alt(3));
    nop(alt(0));
    nop(alt(1));
    for (int i = 0; i < 5; i++) begin
      if (i < 4) cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 4'(i), '0);
      else nop('0);
      if (i >= 1) chk("R9 write burst readback", dq_out, alt(i-1));
    end

    finish_run();
  end
endmodule